// File: doc/BRIEF.md
# Three-wire serial EEPROM word reader

This block fetches one 16-bit word from a word-organised three-wire serial EEPROM. A requester presents a word address and a device-size flag together with a one-cycle start strobe. The engine raises chip select and clocks out a read command frame on the serial data line, most significant bit first. It then clocks in sixteen data bits and hands the assembled word back with a one-cycle completion pulse.

The serial clock is made from the system clock. Every high and every low half-period of the serial clock lasts `DIV` system clocks. The size flag selects the address width for each request: a small device takes a 6-bit address and a larger one takes an 8-bit address. The command frame therefore changes length from one request to the next. A start strobe that arrives while a read is running is dropped.

Top module: `mw_rd_engine`

## Requirements
- R1: The outgoing frame is (address width + 5) bits long and is sent most significant bit first. It holds two zero bits, then the start-and-read pattern 1,1,0, then the address MSB first.
- R2: With `size_i`=0 the address field is 6 bits wide and only `addr_i[5:0]` is used. With `size_i`=1 it is 8 bits wide and uses `addr_i[7:0]`.
- R3: Chip select rises while the serial clock is low and with data-in at 0. The first rising serial clock edge comes exactly 2*DIV system clocks after chip select rises.
- R4: Each frame bit is placed on `di_o` while `sk_o` is low. `di_o` stays stable while `sk_o` is high, and `sk_o` is never high without `cs_o`.
- R5: Every high half-period of `sk_o` lasts exactly DIV system clocks.
- R6: After the last address bit, `di_o` is 0 for one low half-period. It stays 0 throughout the read phase.
- R7: Exactly 16 bits are read, most significant first. Each bit is sampled from `do_i` during a high half-period and shifted in from the right, and the word appears on `data_o`.
- R8: After the 16th bit, `cs_o`, `sk_o` and `di_o` are all low. `done_o` is high for one cycle with `data_o` valid in that same cycle. The pulse is seen (2*(aw+5)+34)*DIV system clocks after the start edge, where aw is the address width.
- R9: A start strobe seen while `busy_o` is high has no effect. The running read completes unchanged and no second read follows.
- R10: After reset, `cs_o`, `sk_o`, `di_o`, `busy_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request strobe |
| size_i | input | 1 | 0: 6-bit address device, 1: 8-bit address device |
| addr_i | input | 8 | Word address, sampled with the strobe |
| do_i | input | 1 | Serial data from the EEPROM |
| cs_o | output | 1 | EEPROM chip select |
| sk_o | output | 1 | EEPROM serial clock |
| di_o | output | 1 | Serial data to the EEPROM |
| busy_o | output | 1 | A read is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| data_o | output | 16 | Word read back |

## Verification
A behavioural EEPROM responder captures the command bits at each rising serial clock edge. It answers from a computed word table. Comparing the captured frame and the returned word separates errors in frame layout, address width or masking from errors in read sampling.

Directed reads cover these cases:
- the all-zero, all-one and signature-like words, which expose shift direction and stuck bits;
- a 6-bit read with the high address bits set, which shows whether masking is applied;
- a start strobe injected mid-read, which shows whether a busy request is dropped.

Seeded random addresses and sizes mix both frame lengths. On each read, the total duration, the high half-period width and the chip-select lead show timing slips that a correct word would hide.

// File: rtl/mw_pkg.sv
package mw_pkg;
  // Phases of one read transaction; each lasts one serial-clock half-period.
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SEL,
    PH_CLO,
    PH_CHI,
    PH_GAP,
    PH_RHI,
    PH_RLO
  } mw_phase_t;

  localparam logic [2:0] RD_CMD     = 3'b110;
  localparam int         LEAD_ZEROS = 2;
  localparam int         CMD_BITS   = 3;
endpackage

// File: rtl/mw_halfper.sv
// Half-period timer: 'last' marks the final system cycle of a serial half-period.
module mw_halfper #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic last
);
  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign last = run && (cnt_q == CNT_W'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || last) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mw_frame.sv
// Builds the command frame left-aligned, plus the number of bits to send.
module mw_frame
  import mw_pkg::*;
#(
  parameter int AW_SMALL = 6,
  parameter int AW_LARGE = 8,
  parameter int FRAME_W  = LEAD_ZEROS + CMD_BITS + AW_LARGE,
  parameter int BCNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic [AW_LARGE-1:0] addr,
  input  logic                size,
  output logic [FRAME_W-1:0]  frame,
  output logic [BCNT_W-1:0]   nbits
);
  localparam int PAD = AW_LARGE - AW_SMALL;

  logic [AW_LARGE-1:0] addr_m;

  // Upper address bits only take part for the larger device.
  for (genvar i = 0; i < AW_LARGE; i++) begin : g_mask
    if (i < AW_SMALL) begin : g_lo
      assign addr_m[i] = addr[i];
    end else begin : g_hi
      assign addr_m[i] = addr[i] & size;
    end
  end

  logic [FRAME_W-1:0] frame_l, frame_s;
  assign frame_l = {{LEAD_ZEROS{1'b0}}, RD_CMD, addr_m};
  assign frame_s = {{LEAD_ZEROS{1'b0}}, RD_CMD, addr_m[AW_SMALL-1:0], {PAD{1'b0}}};

  assign frame = size ? frame_l : frame_s;
  assign nbits = size ? BCNT_W'(FRAME_W) : BCNT_W'(FRAME_W - PAD);
endmodule

// File: rtl/mw_rx.sv
// Receive shifter: bits enter from the right, first bit ends up as MSB.
module mw_rx #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              shift,
  input  logic              bit_i,
  output logic [DATA_W-1:0] word_o
);
  always_ff @(posedge clk) begin
    if (rst || clr) word_o <= '0;
    else if (shift) word_o <= {word_o[DATA_W-2:0], bit_i};
  end
endmodule

// File: rtl/mw_rd_engine.sv
module mw_rd_engine
  import mw_pkg::*;
#(
  parameter int DIV      = 4,   // system clocks per serial half-period, >= 2
  parameter int AW_SMALL = 6,
  parameter int AW_LARGE = 8,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                size_i,
  input  logic [AW_LARGE-1:0] addr_i,
  input  logic                do_i,
  output logic                cs_o,
  output logic                sk_o,
  output logic                di_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [DATA_W-1:0]   data_o
);
  localparam int FRAME_W = LEAD_ZEROS + CMD_BITS + AW_LARGE;
  localparam int BCNT_W  = $clog2(FRAME_W + 1);
  localparam int RCNT_W  = $clog2(DATA_W + 1);

  mw_phase_t          ph_q;
  logic [FRAME_W-1:0] frame_w, shreg_q;
  logic [BCNT_W-1:0]  nbits_w, bits_left_q;
  logic [RCNT_W-1:0]  rd_left_q;
  logic               hp_last;
  logic               accept;
  logic               rx_shift;

  assign accept   = (ph_q == PH_IDLE) && start_i;
  assign rx_shift = (ph_q == PH_RHI) && hp_last;
  assign busy_o   = (ph_q != PH_IDLE);

  mw_frame #(
    .AW_SMALL(AW_SMALL), .AW_LARGE(AW_LARGE), .FRAME_W(FRAME_W), .BCNT_W(BCNT_W)
  ) u_frame (
    .addr (addr_i),
    .size (size_i),
    .frame(frame_w),
    .nbits(nbits_w)
  );

  mw_halfper #(.DIV(DIV)) u_hp (
    .clk (clk),
    .rst (rst),
    .run (busy_o),
    .last(hp_last)
  );

  mw_rx #(.DATA_W(DATA_W)) u_rx (
    .clk   (clk),
    .rst   (rst),
    .clr   (accept),
    .shift (rx_shift),
    .bit_i (do_i),
    .word_o(data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q        <= PH_IDLE;
      cs_o        <= 1'b0;
      sk_o        <= 1'b0;
      di_o        <= 1'b0;
      done_o      <= 1'b0;
      shreg_q     <= '0;
      bits_left_q <= '0;
      rd_left_q   <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (ph_q)
        PH_IDLE: begin
          if (start_i) begin
            ph_q        <= PH_SEL;
            cs_o        <= 1'b1;
            sk_o        <= 1'b0;
            di_o        <= 1'b0;
            shreg_q     <= frame_w;
            bits_left_q <= nbits_w;
          end
        end
        PH_SEL: if (hp_last) begin
          ph_q <= PH_CLO;
          di_o <= shreg_q[FRAME_W-1];
        end
        PH_CLO: if (hp_last) begin
          ph_q <= PH_CHI;
          sk_o <= 1'b1;
        end
        PH_CHI: if (hp_last) begin
          sk_o    <= 1'b0;
          shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
          if (bits_left_q == BCNT_W'(1)) begin
            ph_q <= PH_GAP;
            di_o <= 1'b0;
          end else begin
            ph_q        <= PH_CLO;
            di_o        <= shreg_q[FRAME_W-2];
            bits_left_q <= bits_left_q - 1'b1;
          end
        end
        PH_GAP: if (hp_last) begin
          ph_q      <= PH_RHI;
          sk_o      <= 1'b1;
          rd_left_q <= RCNT_W'(DATA_W);
        end
        PH_RHI: if (hp_last) begin
          ph_q <= PH_RLO;
          sk_o <= 1'b0;
        end
        PH_RLO: if (hp_last) begin
          if (rd_left_q == RCNT_W'(1)) begin
            ph_q   <= PH_IDLE;
            cs_o   <= 1'b0;
            done_o <= 1'b1;
          end else begin
            ph_q      <= PH_RHI;
            sk_o      <= 1'b1;
            rd_left_q <= rd_left_q - 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mw_rd_chk.sv
module mw_rd_chk #(
  parameter int DIV = 4
) (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic cs_o,
  input logic sk_o,
  input logic di_o,
  input logic busy_o,
  input logic done_o
);
  localparam int HW = $clog2(DIV + 1) + 1;

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)       hi_cnt <= '0;
    else if (sk_o) hi_cnt <= hi_cnt + 1'b1;
    else           hi_cnt <= '0;
  end

  // R3
  cs_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_o) |-> (!sk_o && !di_o));

  // R4
  sk_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
    sk_o |-> cs_o);

  // R4
  di_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sk_o && $past(sk_o)) |-> $stable(di_o));

  // R5
  half_period_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sk_o) |-> (hi_cnt == HW'(DIV)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!cs_o && !sk_o && !di_o && !busy_o));

  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  // R9
  cs_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_o) |-> ($past(start_i) && !$past(busy_o)));
endmodule

bind mw_rd_engine mw_rd_chk #(.DIV(DIV)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start_i(start_i),
  .cs_o   (cs_o),
  .sk_o   (sk_o),
  .di_o   (di_o),
  .busy_o (busy_o),
  .done_o (done_o)
);

// File: tb/sim_mw_rd_engine.sv
`timescale 1ns/1ps
module sim_mw_rd_engine;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        size_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        do_r = 1'b0;
  logic        cs_o, sk_o, di_o, busy_o, done_o;
  logic [15:0] data_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mw_rd_engine #(.DIV(DIV)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .size_i(size_i), .addr_i(addr_i),
    .do_i(do_r), .cs_o(cs_o), .sk_o(sk_o), .di_o(di_o), .busy_o(busy_o),
    .done_o(done_o), .data_o(data_o)
  );

  function automatic logic [15:0] word_of(input logic [7:0] a);
    case (a)
      8'h00:   return 16'h8129;
      8'h01:   return 16'h0000;
      8'hFF:   return 16'hFFFF;
      default: return (16'(a) * 16'd977) ^ 16'hC6E5;
    endcase
  endfunction

  function automatic logic [12:0] frame_of(input logic [7:0] a, input logic sz);
    return sz ? {5'b00110, a} : {2'b00, 5'b00110, a[5:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural EEPROM responder and line monitors, sampled on falling clk.
  int          cur_n = 11;
  int          eidx = 0;
  logic [12:0] cap = '0;
  logic        pcs = 1'b0, psk = 1'b0;
  int          hi_run = 0;
  bit          hi_bad = 0;
  bit          rd_di_bad = 0;
  bit          cs_sk_low = 1;
  bit          first_sk = 0;
  int          cs_cnt = 0;
  int          cs_to_sk = 0;

  always @(negedge clk) begin
    if (cs_o && !pcs) begin
      cap = '0; eidx = 0; first_sk = 1; cs_cnt = 0;
      if (sk_o || di_o) cs_sk_low = 0;
    end else if (cs_o && first_sk) begin
      cs_cnt++;
      if (sk_o) begin first_sk = 0; cs_to_sk = cs_cnt; end
    end
    if (!cs_o) begin
      eidx = 0; do_r = 1'b0;
    end else if (sk_o && !psk) begin
      eidx++;
      if (eidx <= cur_n) cap = {cap[11:0], di_o};
      else begin
        logic [7:0]  ad;
        logic [15:0] w;
        int          bp;
        if (di_o) rd_di_bad = 1;
        ad = (cur_n == 13) ? cap[7:0] : {2'b00, cap[5:0]};
        w  = word_of(ad);
        bp = 15 - (eidx - cur_n - 1);
        if (bp >= 0) do_r = w[bp];
      end
    end
    if (sk_o) hi_run++;
    else if (psk) begin
      if (hi_run != DIV) hi_bad = 1;
      hi_run = 0;
    end
    pcs = cs_o; psk = sk_o;
  end

  task automatic do_read(input logic [7:0] a, input logic sz, input bit inject);
    int          cycles;
    int          p;
    logic [7:0]  ea;
    logic [15:0] exp_w;
    @(negedge clk);
    cur_n = sz ? 13 : 11;
    hi_bad = 0; rd_di_bad = 0; cs_sk_low = 1; cs_to_sk = 0;
    addr_i = a; size_i = sz; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    addr_i = ~a;
    cycles = 1;
    while (!done_o && cycles < 5000) begin
      @(negedge clk);
      cycles++;
      if (inject && cycles == 20) begin
        start_i = 1'b1; addr_i = 8'h3C; size_i = ~sz;
      end else begin
        start_i = 1'b0;
      end
    end
    start_i = 1'b0;
    ea    = sz ? a : {2'b00, a[5:0]};
    exp_w = word_of(ea);
    p     = 2 * cur_n + 34;
    chk(done_o == 1'b1, "R8", "done seen", 32'(done_o), 1);
    chk(data_o == exp_w, "R7", "data word", 32'(data_o), 32'(exp_w));
    chk(cap == frame_of(a, sz), sz ? "R1" : "R2", "command frame", 32'(cap), 32'(frame_of(a, sz)));
    chk(cycles == p * DIV + 1, "R8", "done timing", 32'(cycles), 32'(p * DIV + 1));
    chk(!cs_o && !sk_o && !di_o, "R8", "lines low at done", {cs_o, sk_o, di_o}, 0);
    chk(!hi_bad, "R5", "high half-period width", 32'(hi_bad), 0);
    chk(!rd_di_bad, "R6", "di low in read phase", 32'(rd_di_bad), 0);
    chk(cs_sk_low, "R3", "cs rises with sk and di low", 32'(cs_sk_low), 1);
    chk(cs_to_sk == 2 * DIV, "R3", "cs to first sk rise", 32'(cs_to_sk), 32'(2 * DIV));
    @(negedge clk);
    chk(!done_o, "R8", "done one cycle", 32'(done_o), 0);
    if (inject) begin
      repeat (6 * DIV) @(negedge clk);
      chk(!busy_o && !cs_o, "R9", "no second read after busy start", {busy_o, cs_o}, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({cs_o, sk_o, di_o, busy_o, done_o} == 5'b0, "R10", "reset outputs",
        {cs_o, sk_o, di_o, busy_o, done_o}, 0);
    do_read(8'h00, 1'b1, 0);
    do_read(8'hFF, 1'b1, 0);
    do_read(8'h01, 1'b0, 0);
    do_read(8'hC1, 1'b0, 0);   // R2: high address bits masked for small device
    do_read(8'h5A, 1'b1, 1);   // R9: start while busy
    do_read(8'h2D, 1'b0, 1);   // R9
    for (int i = 0; i < 30; i++) begin
      do_read(8'($urandom), 1'($urandom), 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule